// File: doc/BRIEF.md
# SPI Byte Memory with Tiered Write Protection

This block is the serial front end of a 2 KB byte-addressed memory that has no write delay. An SPI mode-0 host talks to it over chip select, serial clock and data lines. The block decodes each command byte, moves bytes between the serial lines and an internal synchronous array, and keeps a status register that decides which writes are allowed. The serial pins are oversampled by the block clock. Each of `cs_n`, `sck` and `mosi` must hold for at least two block-clock cycles between changes.

Writes are allowed only when three conditions all hold. First, a write-enable latch must have been set by its own command. That latch drops when chip select rises after any complete write. Second, a two-bit block-protect field must leave the target address outside the locked upper part of the address space. Third, a status write is refused when the protect-enable bit is set and the active-low protect pin is low. That pin has no effect on the array.

Opcodes: 0x06 set latch, 0x04 clear latch, 0x05 read status, 0x01 write status, 0x03 read array, 0x02 write array. Data moves MSB first. Input bits are taken on rising `sck`, and output bits change on falling `sck`.

Top module: `spiwp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00.
- R2: The status byte is {prot_en, 0, 0, 0, bp[1], bp[0], wel, 0}, MSB first. Bits 6..4 and bit 0 always read 0, whatever value a status write supplies, so writing 0xFF with the latch set yields 0x8C.
- R3: A read-status command (0x05) returns the status byte once, in the byte after the opcode. Any further bytes in that same select return 0x00.
- R4: Opcode 0x06 sets wel and opcode 0x04 clears it.
- R5: When chip select rises after at least one complete data byte of a write-array (0x02) or write-status (0x01) command, wel is cleared, even if that byte was refused. A select that carries only 0x06 leaves wel set.
- R6: When wel is 0, array writes and status writes change nothing.
- R7: A status write is refused when prot_en is 1 and wp_n is 0. When prot_en is 0, wp_n is ignored. wp_n never blocks array writes.
- R8: Block protect bp=00 locks nothing, 01 locks 0x600-0x7FF, 10 locks 0x400-0x7FF and 11 locks every address. The check is made separately for each byte of a burst, and a locked byte is dropped without any error.
- R9: Read (0x03) and write (0x02) take two address bytes, of which the low 11 bits are used. The address then advances by one per data byte and wraps from 0x7FF to 0x000.
- R10: An unknown opcode makes the rest of that select, including any later bytes, have no effect.
- R11: A byte cut short by chip select rising is never acted on, and it does not count as a completed write for R5.
- R12: miso is 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data from host |
| wp_n | input | 1 | Active-low status write-protect pin |
| miso | output | 1 | Serial data to host |

## Verification
The hardest cases to reach are the ones where two protection tiers interact. One is a status write refused by the pin while prot_en is set, which must still drop wel. Another is a single burst that crosses from an unlocked address into a locked one, where only the unlocked bytes may land. The stimulus reaches these by first programming the status register while the pin is high, then dropping the pin. It then writes bursts that straddle 0x5FF/0x600 and 0x3FF/0x400, and reads every byte back. A select aborted after four bits of a data byte shows that a partial byte neither writes the array nor clears the latch.

// File: rtl/spiwp_pkg.sv
package spiwp_pkg;
    localparam logic [7:0] OP_SET_WEL = 8'h06;
    localparam logic [7:0] OP_CLR_WEL = 8'h04;
    localparam logic [7:0] OP_RD_STAT = 8'h05;
    localparam logic [7:0] OP_WR_STAT = 8'h01;
    localparam logic [7:0] OP_RD_MEM  = 8'h03;
    localparam logic [7:0] OP_WR_MEM  = 8'h02;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_AHI,
        PH_ALO,
        PH_RDAT,
        PH_WDAT,
        PH_SDAT,
        PH_SOUT,
        PH_IDLE
    } phase_e;
endpackage

// File: rtl/spiwp_mem.sv
module spiwp_mem #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] arr [DEPTH];

    always_ff @(posedge clk) begin
        if (we) arr[waddr] <= wdata;
        rdata <= arr[raddr];
    end
endmodule

// File: rtl/spiwp_prot.sv
module spiwp_prot #(
    parameter int ADDR_W = 11
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    always_comb begin
        unique case (bp)
            2'b00:   locked = 1'b0;
            2'b01:   locked = (addr[ADDR_W-1 -: 2] == 2'b11);
            2'b10:   locked = addr[ADDR_W-1];
            default: locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/spiwp_ctrl.sv
module spiwp_ctrl #(
    parameter int ADDR_W = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    input  logic wp_n,
    output logic miso
);
    import spiwp_pkg::*;

    localparam int HI_W = ADDR_W - 8;

    typedef struct packed {
        phase_e            phase;
        logic [2:0]        cnt;
        logic [7:0]        sh;
        logic              is_rd;
        logic [HI_W-1:0]   ahi;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        osh;
        logic              wel;
        logic              wpen;
        logic [1:0]        bp;
        logic              wr_seen;
        logic              sck_q;
    } st_t;

    st_t st_d, st_q;

    logic              mem_we;
    logic              sr_we;
    logic              locked;
    logic [7:0]        mem_rdata;
    logic [7:0]        byte_in;
    logic [7:0]        status;
    logic              sck_rise, sck_fall;

    spiwp_mem #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (st_q.addr),
        .wdata (byte_in),
        .raddr (st_q.addr),
        .rdata (mem_rdata)
    );

    spiwp_prot #(.ADDR_W(ADDR_W)) u_prot (
        .bp     (st_q.bp),
        .addr   (st_q.addr),
        .locked (locked)
    );

    assign byte_in  = {st_q.sh[6:0], mosi};
    assign status   = {st_q.wpen, 3'b000, st_q.bp, st_q.wel, 1'b0};
    assign sck_rise = sck && !st_q.sck_q;
    assign sck_fall = !sck && st_q.sck_q;
    assign miso     = st_q.osh[7];

    always_comb begin
        st_d       = st_q;
        st_d.sck_q = sck;
        mem_we     = 1'b0;
        sr_we      = 1'b0;
        if (cs_n) begin
            st_d.phase   = PH_OPC;
            st_d.cnt     = '0;
            st_d.osh     = '0;
            st_d.wr_seen = 1'b0;
            if (st_q.wr_seen) st_d.wel = 1'b0;
        end else if (sck_rise) begin
            st_d.sh  = byte_in;
            st_d.cnt = st_q.cnt + 3'd1;
            if (st_q.cnt == 3'd7) begin
                unique case (st_q.phase)
                    PH_OPC: begin
                        st_d.phase = PH_IDLE;
                        unique case (byte_in)
                            OP_SET_WEL: st_d.wel = 1'b1;
                            OP_CLR_WEL: st_d.wel = 1'b0;
                            OP_RD_STAT: st_d.phase = PH_SOUT;
                            OP_WR_STAT: st_d.phase = PH_SDAT;
                            OP_RD_MEM, OP_WR_MEM: begin
                                st_d.phase = PH_AHI;
                                st_d.is_rd = (byte_in == OP_RD_MEM);
                            end
                            default: st_d.phase = PH_IDLE;
                        endcase
                    end
                    PH_AHI: begin
                        st_d.ahi   = byte_in[HI_W-1:0];
                        st_d.phase = PH_ALO;
                    end
                    PH_ALO: begin
                        st_d.addr  = {st_q.ahi, byte_in};
                        st_d.phase = st_q.is_rd ? PH_RDAT : PH_WDAT;
                    end
                    PH_WDAT: begin
                        st_d.wr_seen = 1'b1;
                        mem_we       = st_q.wel && !locked;
                        st_d.addr    = st_q.addr + 1'b1;
                    end
                    PH_SDAT: begin
                        st_d.wr_seen = 1'b1;
                        st_d.phase   = PH_IDLE;
                        if (st_q.wel && (wp_n || !st_q.wpen)) begin
                            sr_we     = 1'b1;
                            st_d.wpen = byte_in[7];
                            st_d.bp   = byte_in[3:2];
                        end
                    end
                    PH_SOUT: st_d.phase = PH_IDLE;
                    default: ;
                endcase
            end
        end else if (sck_fall) begin
            if (st_q.cnt == 3'd0 && st_q.phase == PH_SOUT) begin
                st_d.osh = status;
            end else if (st_q.cnt == 3'd0 && st_q.phase == PH_RDAT) begin
                st_d.osh  = mem_rdata;
                st_d.addr = st_q.addr + 1'b1;
            end else begin
                st_d.osh = {st_q.osh[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_OPC;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spiwp_chk.sv
module spiwp_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              wp_n,
    input logic              miso,
    input logic              wel,
    input logic              wpen,
    input logic [1:0]        bp,
    input logic              wr_seen,
    input logic              mem_we,
    input logic              sr_we,
    input logic [ADDR_W-1:0] addr
);
    localparam int DEPTH = 1 << ADDR_W;

    int unsigned lock_lo;
    always_comb begin
        case (bp)
            2'b00:   lock_lo = DEPTH;
            2'b01:   lock_lo = (DEPTH / 4) * 3;
            2'b10:   lock_lo = DEPTH / 2;
            default: lock_lo = 0;
        endcase
    end

    a_r8_no_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (int'(addr) < int'(lock_lo)));

    a_r6_array_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel);

    a_r7_status_gate: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |-> (wel && (wp_n || !wpen)));

    a_r2_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_we |=> $stable({wpen, bp}));

    a_r5_wel_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_n) && wr_seen) |=> !wel);

    a_r12_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !miso);
endmodule

bind spiwp_ctrl spiwp_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .wp_n    (wp_n),
    .miso    (miso),
    .wel     (status[1]),
    .wpen    (status[7]),
    .bp      (status[3:2]),
    .wr_seen (st_q.wr_seen),
    .mem_we  (mem_we),
    .sr_we   (sr_we),
    .addr    (st_q.addr)
);

// File: tb/sim_spiwp_ctrl.sv
`timescale 1ns/1ps
module sim_spiwp_ctrl;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic wp_n = 1'b1;
    logic miso;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    bit        m_wel = 0;
    bit        m_wpen = 0;
    bit [1:0]  m_bp = 0;
    bit [7:0]  mm [2048];

    always #2.5 clk = ~clk;

    spiwp_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
        .mosi(mosi), .wp_n(wp_n), .miso(miso)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // R12: miso idle low while select is high
    bit cs_prev = 1'b1;
    always @(negedge clk) begin
        if (rst_n && cs_n && cs_prev) begin
            tests++;
            if (miso !== 1'b0) begin
                fails++;
                $display("FAIL R12: miso got %b expected 0", miso);
            end
        end
        cs_prev = cs_n;
    end

    function automatic bit m_locked(input int a);
        case (m_bp)
            2'd0: return 0;
            2'd1: return a >= 'h600;
            2'd2: return a >= 'h400;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] m_status();
        return {m_wpen, 3'b000, m_bp, m_wel, 1'b0};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            wait_clk(HALF);
            rx[i] = miso;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic desel();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic op_simple(input logic [7:0] opc);
        logic [7:0] r;
        sel(); spi_byte(opc, r); desel();
        if (opc == 8'h06) m_wel = 1;
        if (opc == 8'h04) m_wel = 0;
    endtask

    task automatic op_rdsr(input string req);
        logic [7:0] r;
        sel(); spi_byte(8'h05, r); spi_byte(8'h00, r); desel();
        chk(req, r, m_status());
    endtask

    task automatic op_wrsr(input logic [7:0] v);
        logic [7:0] r;
        sel(); spi_byte(8'h01, r); spi_byte(v, r); desel();
        if (m_wel && (wp_n || !m_wpen)) begin
            m_wpen = v[7];
            m_bp = v[3:2];
        end
        m_wel = 0;
    endtask

    task automatic op_write(input int a, input logic [7:0] d[$]);
        logic [7:0] r;
        sel();
        spi_byte(8'h02, r); spi_byte(8'(a >> 8), r); spi_byte(8'(a), r);
        foreach (d[i]) begin
            spi_byte(d[i], r);
            if (m_wel && !m_locked((a + i) % 2048)) mm[(a + i) % 2048] = d[i];
        end
        desel();
        if (d.size() > 0) m_wel = 0;
    endtask

    task automatic op_read(input string req, input int a, input int n);
        logic [7:0] r;
        sel();
        spi_byte(8'h03, r); spi_byte(8'(a >> 8), r); spi_byte(8'(a), r);
        for (int i = 0; i < n; i++) begin
            spi_byte(8'h00, r);
            chk(req, r, mm[(a + i) % 2048]);
        end
        desel();
    endtask

    initial begin
        logic [7:0] r;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        op_rdsr("R1 reset status");

        // R3: only one status byte, then zeros
        sel(); spi_byte(8'h05, r); spi_byte(8'h00, r);
        chk("R3 first", r, m_status());
        spi_byte(8'h00, r); chk("R3 trailing", r, 8'h00);
        desel();

        op_simple(8'h06); op_rdsr("R4 set wel");
        op_simple(8'h04); op_rdsr("R4 clear wel");

        op_simple(8'h06); op_write('h010, '{8'h11, 8'h22});
        op_rdsr("R5 wel cleared after write");
        op_read("R9 basic read", 'h010, 2);
        op_write('h010, '{8'h99}); op_read("R6 array no wel", 'h010, 1);
        op_wrsr(8'h8C); op_rdsr("R6 status no wel");

        op_simple(8'h06); op_rdsr("R5 wel persists");
        op_rdsr("R5 wel persists again");

        op_write('h7FE, '{8'hA1, 8'hA2, 8'hA3, 8'hA4});
        op_read("R9 wrap", 'h7FE, 4);

        op_simple(8'h06); op_write('h5FE, '{8'h01, 8'h02, 8'h03, 8'h04});
        op_simple(8'h06); op_write('h3FE, '{8'h05, 8'h06, 8'h07, 8'h08});
        op_simple(8'h06); op_write('h000, '{8'h0A});
        op_simple(8'h06); op_wrsr(8'h04); op_rdsr("R2 bp=01");
        op_simple(8'h06); op_write('h5FE, '{8'hB1, 8'hB2, 8'hB3, 8'hB4});
        op_read("R8 quarter", 'h5FE, 4);
        op_simple(8'h06); op_wrsr(8'h08); op_rdsr("R2 bp=10");
        op_simple(8'h06); op_write('h3FE, '{8'hC1, 8'hC2, 8'hC3, 8'hC4});
        op_read("R8 half", 'h3FE, 4);
        op_simple(8'h06); op_wrsr(8'hFF); op_rdsr("R2 reserved bits");
        op_simple(8'h06); op_write('h000, '{8'hD1});
        op_read("R8 all", 'h000, 1);

        wp_n = 1'b0;
        op_simple(8'h06); op_wrsr(8'h00); op_rdsr("R7 pin blocks");
        wp_n = 1'b1;
        op_simple(8'h06); op_wrsr(8'h00); op_rdsr("R7 pin high allows");
        wp_n = 1'b0;
        op_simple(8'h06); op_wrsr(8'h04); op_rdsr("R7 pin ignored wpen0");
        op_simple(8'h06); op_wrsr(8'h00); op_rdsr("R7 clear bp");
        op_simple(8'h06); op_write('h020, '{8'h5A});
        op_read("R7 array with pin low", 'h020, 1);
        wp_n = 1'b1;

        sel(); spi_byte(8'hAB, r); spi_byte(8'h06, r); desel();
        op_rdsr("R10 unknown opcode");

        op_simple(8'h06);
        sel();
        spi_byte(8'h02, r); spi_byte(8'h00, r); spi_byte(8'h20, r);
        for (int i = 7; i >= 4; i--) begin
            mosi = 1'b1; wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
        end
        desel();
        op_read("R11 partial byte", 'h020, 1);
        op_rdsr("R11 wel kept");
        op_simple(8'h04);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule